// File: doc/BRIEF.md
# Dual-Interval Restart Timer

This block counts clock cycles for a two-road light sequencer. The sequencer raises a one-cycle restart pulse each time it changes state. The pulse clears the count to zero, and counting then resumes on every clock edge. Two flags are compared against that count. `short_done_o` rises once `SHORT_COUNT` cycles have passed, and `long_done_o` rises once `LONG_COUNT` cycles have passed. The sequencer uses these flags to decide when to leave its green and yellow phases.

When the count reaches `LONG_COUNT` the counter stops. Both flags then stay high until the next restart pulse. Two parameters select variants of the timer. `CLEAR_MODE` makes the restart clear either synchronous (the clear happens at the clock edge that samples the pulse) or asynchronous (the clear happens as soon as the pulse rises). `START_MODE` chooses how the restart pulse is taken in. In direct mode it is used as it arrives, in the same cycle as the sequencer's decision. In registered mode the block first captures it in a flop, which delays it by one clock.

All pins are single-bit control and status lines with no handshake.

Top module: `interval_timer_dual`

## Requirements
- R1: An active-high asynchronous reset clears the count and the registered restart flop, so both flags read 0 during reset. After reset is released with no restart pulse, the count advances by one on each clock edge, starting from zero.
- R2: A restart pulse clears the count to zero and starts counting again, even when it arrives partway through an interval.
- R3: `short_done_o` is 1 exactly when the count is at least `SHORT_COUNT`. It rises `SHORT_COUNT` edges after the clearing edge.
- R4: `long_done_o` is 1 exactly when the count is at least `LONG_COUNT`. It rises `LONG_COUNT` edges after the clearing edge.
- R5: The counter stops at `LONG_COUNT`, and both flags stay at 1 until the next restart pulse.
- R6: A restart pulse that arrives while the counter is stopped starts a new count from zero.
- R7: With `CLEAR_MODE` = `CLEAR_SYNC` (enum value 0), the flags hold their value until the clock edge that samples the clear, and drop at that edge.
- R8: With `CLEAR_MODE` = `CLEAR_ASYNC` (enum value 1), the flags drop as soon as the clear rises, without waiting for a clock edge. The count is held at zero for as long as the clear stays high.
- R9: With `START_MODE` = `START_DIRECT` (enum value 0), the clearing edge is the edge that samples `start_i`. With `START_REGISTERED` (enum value 1), `start_i` passes through a flop first, so the clear and every later flag edge occur one clock later.
- R10: The count never exceeds `LONG_COUNT`, and `long_done_o` is never 1 while `short_done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| start_i | input | 1 | Restart pulse from the sequencer |
| short_done_o | output | 1 | Short interval has elapsed |
| long_done_o | output | 1 | Long interval has elapsed; the counter is stopped |

## Verification
The hardest situation to reach from the ports is a restart that lands on a counter already stopped at its limit. This is the only point where the four variants differ in when the flags drop. The stimulus waits long enough for every variant to stop, then gives one restart pulse. It samples the flags before the next edge, one cycle later and two cycles later, which separates the immediate, same-edge and one-clock-delayed drops. A table of restart gaps then places pulses before the short limit, between the two limits and after the stop, with every cycle of each gap compared in all four variants.

// File: rtl/itd_pkg.sv
package itd_pkg;

  typedef enum logic {
    CLEAR_SYNC  = 1'b0,
    CLEAR_ASYNC = 1'b1
  } clear_mode_e;

  typedef enum logic {
    START_DIRECT     = 1'b0,
    START_REGISTERED = 1'b1
  } start_mode_e;

endpackage

// File: rtl/itd_start_stage.sv
module itd_start_stage
  import itd_pkg::*;
#(
  parameter start_mode_e START_MODE = START_DIRECT
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic clr_o
);

  generate
    if (START_MODE == START_REGISTERED) begin : g_registered
      logic start_q;

      always_ff @(posedge clk or posedge rst) begin
        if (rst) start_q <= 1'b0;
        else     start_q <= start_i;
      end

      assign clr_o = start_q;

      // R9: a clear in registered mode rises only after a sampled request
      assert_reg_start_delay_R9: assert property (
        @(posedge clk) disable iff (rst)
        $rose(clr_o) |-> $past(start_i)
      ) else $error("registered clear without prior start");
    end else begin : g_direct
      assign clr_o = start_i;
    end
  endgenerate

endmodule

// File: rtl/itd_count_core.sv
module itd_count_core
  import itd_pkg::*;
#(
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned LIMIT      = 12,
  parameter clear_mode_e CLEAR_MODE = CLEAR_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run;

  // counting continues only while below the long limit
  assign run   = (cnt_q < LIMIT_V);
  assign cnt_o = cnt_q;

  generate
    if (CLEAR_MODE == CLEAR_ASYNC) begin : g_async_clear
      always_ff @(posedge clk or posedge rst or posedge clr_i) begin
        if (rst)        cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (run)   cnt_q <= cnt_q + ONE_V;
      end

      // R8: while the clear is high the count already reads zero at the edge
      assert_async_clear_zero_R8: assert property (
        @(posedge clk) disable iff (rst)
        clr_i |-> (cnt_q == '0)
      ) else $error("async clear did not hold count at zero");
    end else begin : g_sync_clear
      always_ff @(posedge clk or posedge rst) begin
        if (rst)        cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (run)   cnt_q <= cnt_q + ONE_V;
      end

      // R7: a sampled clear produces zero after that edge
      assert_sync_clear_zero_R7: assert property (
        @(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0)
      ) else $error("sync clear did not zero the count");
    end
  endgenerate

  // R2: without a clear, a running count advances by exactly one
  assert_step_by_one_R2: assert property (
    @(posedge clk) disable iff (rst)
    (!clr_i && run) |=> ((cnt_q == $past(cnt_q) + ONE_V) || clr_i)
  ) else $error("count did not advance by one");

  // R5: a stopped count stays at the limit until a clear
  assert_hold_at_limit_R5: assert property (
    @(posedge clk) disable iff (rst)
    (!clr_i && !run) |=> ((cnt_q == LIMIT_V) || clr_i)
  ) else $error("stopped count moved without a clear");

  // R10: the count stays within its limit
  assert_no_overrun_R10: assert property (
    @(posedge clk) disable iff (rst)
    cnt_q <= LIMIT_V
  ) else $error("count beyond long limit");

endmodule

// File: rtl/itd_flag_decode.sv
module itd_flag_decode #(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SHORT_LIMIT = 5,
  parameter int unsigned LONG_LIMIT  = 12
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             short_o,
  output logic             long_o
);

  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_LIMIT);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_LIMIT);

  always_comb begin
    short_o = (cnt_i >= SHORT_V);
    long_o  = (cnt_i >= LONG_V);
  end

endmodule

// File: rtl/interval_timer_dual.sv
module interval_timer_dual
  import itd_pkg::*;
#(
  parameter int unsigned SHORT_COUNT = 5,
  parameter int unsigned LONG_COUNT  = 12,
  parameter clear_mode_e CLEAR_MODE  = CLEAR_SYNC,
  parameter start_mode_e START_MODE  = START_DIRECT
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic short_done_o,
  output logic long_done_o
);

  localparam int unsigned CNT_W = $clog2(LONG_COUNT + 1);

  logic             clr_w;
  logic [CNT_W-1:0] cnt_w;

  itd_start_stage #(
    .START_MODE (START_MODE)
  ) start_stage_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .clr_o   (clr_w)
  );

  itd_count_core #(
    .CNT_W      (CNT_W),
    .LIMIT      (LONG_COUNT),
    .CLEAR_MODE (CLEAR_MODE)
  ) count_core_i (
    .clk   (clk),
    .rst   (rst),
    .clr_i (clr_w),
    .cnt_o (cnt_w)
  );

  itd_flag_decode #(
    .CNT_W       (CNT_W),
    .SHORT_LIMIT (SHORT_COUNT),
    .LONG_LIMIT  (LONG_COUNT)
  ) flag_decode_i (
    .cnt_i   (cnt_w),
    .short_o (short_done_o),
    .long_o  (long_done_o)
  );

  // R10: the long flag never stands without the short flag
  assert_long_implies_short_R10: assert property (
    @(posedge clk) disable iff (rst)
    long_done_o |-> short_done_o
  ) else $error("long flag without short flag");

  // R2: a flag only falls because of a clear
  assert_flags_fall_on_clear_R2: assert property (
    @(posedge clk) disable iff (rst)
    $fell(short_done_o) |-> (clr_w || $past(clr_w))
  ) else $error("short flag fell without a clear");

endmodule

// File: tb/interval_timer_dual_tb_top.sv
module interval_timer_dual_tb_top;
  import itd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SHORT_N    = 5;
  localparam int LONG_N     = 12;
  localparam int NCFG       = 4;
  localparam int NVEC       = 8;
  // cycles watched after each restart pulse
  localparam int WAIT_TAB [NVEC] = '{3, 8, 16, 2, 12, 13, 6, 20};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NCFG-1:0] short_w;
  logic [NCFG-1:0] long_w;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // cfg index bit0: async clear, bit1: registered start
  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    interval_timer_dual #(
      .SHORT_COUNT (SHORT_N),
      .LONG_COUNT  (LONG_N),
      .CLEAR_MODE  ((k % 2) == 1 ? CLEAR_ASYNC : CLEAR_SYNC),
      .START_MODE  ((k / 2) == 1 ? START_REGISTERED : START_DIRECT)
    ) dut_i (
      .clk          (clk),
      .rst          (rst),
      .start_i      (start),
      .short_done_o (short_w[k]),
      .long_done_o  (long_w[k])
    );
  end

  task automatic check_bit(input logic act, input logic exp, input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // compare both flags of one variant against an expected count value
  task automatic check_cfg(input int k, input int c, input string ctx);
    string rs;
    string rl;
    string ex;
    rs = (c >= LONG_N) ? "R5" : "R3";
    rl = (c >= LONG_N) ? "R5" : "R4";
    ex = (k >= 2) ? " R9 registered" : "";
    check_bit(short_w[k], c >= SHORT_N, rs, $sformatf("cfg%0d short count=%0d %s%s", k, c, ctx, ex));
    check_bit(long_w[k], c >= LONG_N, rl, $sformatf("cfg%0d long count=%0d %s%s", k, c, ctx, ex));
    check_bit(long_w[k] & ~short_w[k], 1'b0, "R10", $sformatf("cfg%0d flag order", k));
  endtask

  task automatic pulse_and_watch(input int w, input string ctx);
    @(negedge clk);
    start = 1'b1;
    for (int j = 0; j < w; j++) begin
      @(negedge clk);
      start = 1'b0;
      #2;
      for (int k = 0; k < NCFG; k++) begin
        int c;
        c = j - (k / 2);
        if (c >= 0) begin
          if (c > LONG_N) c = LONG_N;
          check_cfg(k, c, ctx);
        end
      end
    end
  endtask

  task automatic watch_from_reset(input int w);
    for (int j = 0; j < w; j++) begin
      @(negedge clk);
      #2;
      for (int k = 0; k < NCFG; k++) begin
        int c;
        c = (j + 1 > LONG_N) ? LONG_N : j + 1;
        check_cfg(k, c, "R1 after reset");
      end
    end
  endtask

  task automatic show_summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    // R1: flags low during reset
    repeat (2) begin
      @(negedge clk);
      #1;
      for (int k = 0; k < NCFG; k++) begin
        check_bit(short_w[k], 1'b0, "R1", $sformatf("cfg%0d short in reset", k));
        check_bit(long_w[k], 1'b0, "R1", $sformatf("cfg%0d long in reset", k));
      end
    end
    @(negedge clk);
    rst = 1'b0;
    watch_from_reset(LONG_N + 3);

    // table of restart gaps
    begin
      int prev_w;
      prev_w = LONG_N + 3;
      for (int v = 0; v < NVEC; v++) begin
        pulse_and_watch(WAIT_TAB[v],
          (prev_w >= LONG_N + 2) ? "R6 restart after stop" : "R2 restart while counting");
        prev_w = WAIT_TAB[v];
      end
    end

    // directed: drop timing from a stopped counter, all variants
    @(negedge clk);
    start = 1'b1;
    #1;
    check_bit(short_w[1], 1'b0, "R8", "async direct short drops before edge");
    check_bit(long_w[1], 1'b0, "R8", "async direct long drops before edge");
    check_bit(short_w[0], 1'b1, "R7", "sync direct short held before edge");
    check_bit(long_w[0], 1'b1, "R7", "sync direct long held before edge");
    check_bit(long_w[2], 1'b1, "R9", "sync registered long held before edge");
    check_bit(long_w[3], 1'b1, "R9", "async registered long held before edge");
    @(negedge clk);
    start = 1'b0;
    #2;
    check_bit(long_w[0], 1'b0, "R7", "sync direct long dropped at edge");
    check_bit(short_w[0], 1'b0, "R7", "sync direct short dropped at edge");
    check_bit(long_w[3], 1'b0, "R8", "async registered long dropped after register");
    check_bit(long_w[2], 1'b1, "R9", "sync registered long held one more edge");
    check_bit(short_w[2], 1'b1, "R9", "sync registered short held one more edge");
    @(negedge clk);
    #2;
    check_bit(long_w[2], 1'b0, "R9", "sync registered long dropped one edge later");

    // directed: clear held high for several cycles keeps the count at zero
    @(negedge clk);
    start = 1'b1;
    repeat (SHORT_N + 2) @(negedge clk);
    #2;
    for (int k = 0; k < NCFG; k++)
      check_bit(short_w[k], 1'b0, "R8", $sformatf("cfg%0d held clear keeps short low", k));
    start = 1'b0;
    repeat (LONG_N + 3) @(negedge clk);

    // directed: reset in the middle of operation
    @(negedge clk);
    rst = 1'b1;
    #1;
    for (int k = 0; k < NCFG; k++) begin
      check_bit(short_w[k], 1'b0, "R1", $sformatf("cfg%0d short on mid-run reset", k));
      check_bit(long_w[k], 1'b0, "R1", $sformatf("cfg%0d long on mid-run reset", k));
    end
    @(negedge clk);
    rst = 1'b0;
    watch_from_reset(SHORT_N + 2);

    finished = 1'b1;
    show_summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      show_summary();
      $finish;
    end
  end

endmodule